// File: doc/BRIEF.md
# Disk NMI Enable and Source Register

This block raises the non-maskable interrupt for a floppy disk subsystem. One register location serves two purposes. Writing it sets two enable bits: one lets the disk controller's interrupt request cause an NMI, and the other lets a motor timeout cause one. Reading the same location returns the live state of the possible sources: the controller interrupt, the motor timeout and the front-panel reset button. A source that is active reads as 0.

The enables are captured when the write strobe ends. This matches a bus in which data is only guaranteed valid at the trailing edge of the strobe. A motor timeout arrives as a one-cycle event. The block holds it as a flag until the enables are written again or the motor is restarted, so software always finds the cause of the interrupt. The controller request and the button come in asynchronously and pass through a synchronizer whose depth is set by a parameter. NMI is driven from a register, so a glitch on a source cannot reach the CPU.

Top module: `nmi_ctl`

## Requirements
- R1: After reset both enable bits are clear, the timeout flag is clear and `nmi` is 0.
- R2: The enables are taken from `wdata` bit 7 (controller request) and bit 6 (motor timeout) as `wr_stb` falls. They load on the first clock edge that finds `wr_stb` low after it was high, using the data last seen while the strobe was high. While the strobe is high they do not change.
- R3: With enable bit 7 set, a synchronized controller request drives `nmi` to 1. With that bit clear, the request has no effect on `nmi`.
- R4: With enable bit 6 set, a set timeout flag drives `nmi` to 1. With that bit clear, the flag has no effect on `nmi`.
- R5: During a read (`rd_stb` high), `rdata` bit 7 is 0 when the synchronized controller request is active and 1 when it is not.
- R6: During a read, `rdata` bit 6 is 0 while the timeout flag is set, and bit 5 is 0 while the synchronized panel button is pressed. Each is 1 otherwise.
- R7: During a read, `rdata` bits 4 to 0 are 1. With `rd_stb` low, all of `rdata` is 1.
- R8: A `tmo_pulse` sets the timeout flag on the next clock edge. The flag stays set until an enable write completes or `motor_start` is pulsed.
- R9: `nmi` is registered. It rises exactly SYNC_STAGES+1 clock edges after the controller request rises (with its enable set), and 2 edges after a timeout pulse (with its enable set).
- R10: `wdata` bits 5 to 0 have no effect on the enables or on the read status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe; the enables load as it falls |
| rd_stb | input | 1 | Read strobe; gates the status onto `rdata` |
| wdata | input | DATA_W | Write data |
| fdc_irq | input | 1 | Disk controller interrupt request, asynchronous, active high |
| tmo_pulse | input | 1 | One-cycle motor timeout event |
| motor_start | input | 1 | One-cycle motor restart event; clears the timeout flag |
| panel_btn | input | 1 | Front-panel reset button, asynchronous, active high when pressed |
| nmi | output | 1 | Non-maskable interrupt, active high |
| rdata | output | DATA_W | Read status, active-low source bits |

## Verification
The bench goes after the write strobe's timing. It holds a strobe high for several cycles with the controller request already active and its enable bit in the data. A design that loaded the enables on the rising edge of the strobe would raise NMI too early, and the bench reports that. It counts the edges from a source rising to `nmi` rising, which exposes a missing output register or the wrong synchronizer depth. It writes values that differ only in bits 5 to 0, to catch a design that decodes the wrong bits. It checks that the timeout flag survives until an enable write or a motor restart. A design that let the flag follow the pulse would read bit 6 as 1 and would never raise NMI from a timeout. A random phase with a fixed seed mixes all of these events and checks the read status and `nmi` against a model built from the requirements.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
   // Bit positions fixed by the software view of the register
   localparam int unsigned BIT_IRQ  = 7;
   localparam int unsigned BIT_TMO  = 6;
   localparam int unsigned BIT_BTN  = 5;
   localparam int unsigned MIN_DATA = 8;

   typedef struct packed {
      logic irq;
      logic tmo;
   } nmi_en_t;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= din;
            else chain_q <= {chain_q[STAGES-2:0], din};
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nmi_mask.sv
module nmi_mask
   import nmi_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_stb,
   input  nmi_en_t wr_bits,
   output nmi_en_t en,
   output logic    commit
);
   logic    stb_q;
   nmi_en_t stage_q;

   // Load on the first edge that sees the strobe low after it was high
   assign commit = stb_q & ~wr_stb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_q   <= 1'b0;
         stage_q <= '0;
         en      <= '0;
      end else begin
         stb_q <= wr_stb;
         if (wr_stb) stage_q <= wr_bits;
         if (commit) en <= stage_q;
      end
   end
endmodule

// File: rtl/nmi_tmo_flag.sv
module nmi_tmo_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pulse,
   input  logic clr_write,
   input  logic clr_restart,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)                       flag <= 1'b0;
      else if (set_pulse)               flag <= 1'b1;
      else if (clr_write | clr_restart) flag <= 1'b0;
   end
endmodule

// File: rtl/nmi_ctl.sv
module nmi_ctl
   import nmi_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fdc_irq,
   input  logic              tmo_pulse,
   input  logic              motor_start,
   input  logic              panel_btn,
   output logic              nmi,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned LOW_BITS = BIT_BTN;

   initial begin
      assert (DATA_W >= MIN_DATA) else $error("nmi_ctl: DATA_W below %0d", MIN_DATA);
      assert (SYNC_STAGES <= 4) else $error("nmi_ctl: SYNC_STAGES above 4");
   end

   logic    irq_s, btn_s, commit, tmo_q;
   nmi_en_t wr_bits, en;
   logic [DATA_W-1:0] status;

   assign wr_bits.irq = wdata[BIT_IRQ];
   assign wr_bits.tmo = wdata[BIT_TMO];

   nmi_sync #(.STAGES(SYNC_STAGES)) u_sync_irq (
      .clk(clk), .rst_n(rst_n), .din(fdc_irq), .dout(irq_s));
   nmi_sync #(.STAGES(SYNC_STAGES)) u_sync_btn (
      .clk(clk), .rst_n(rst_n), .din(panel_btn), .dout(btn_s));

   nmi_mask u_mask (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_bits(wr_bits),
      .en(en), .commit(commit));

   nmi_tmo_flag u_tmo (
      .clk(clk), .rst_n(rst_n), .set_pulse(tmo_pulse),
      .clr_write(commit), .clr_restart(motor_start), .flag(tmo_q));

   always_ff @(posedge clk) begin
      if (!rst_n) nmi <= 1'b0;
      else        nmi <= (en.irq & irq_s) | (en.tmo & tmo_q);
   end

   always_comb begin
      status               = '1;
      status[BIT_IRQ]      = ~irq_s;
      status[BIT_TMO]      = ~tmo_q;
      status[BIT_BTN]      = ~btn_s;
      status[LOW_BITS-1:0] = '1;
   end

   assign rdata = rd_stb ? status : '1;
endmodule

// File: rtl/nmi_chk.sv
module nmi_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic              tmo_pulse,
   input logic              motor_start,
   input logic              commit,
   input logic              en_irq,
   input logic              en_tmo,
   input logic              tmo_q,
   input logic              nmi,
   input logic [DATA_W-1:0] rdata
);
   assert_stable_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> ($stable(en_irq) && $stable(en_tmo)));

   assert_tmo_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |=> tmo_q);

   assert_tmo_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmo_q) |-> ($past(commit) || $past(motor_start)));

   assert_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en_irq) && !$past(tmo_q)) |-> !nmi);

   assert_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en_tmo) && !$past(en_irq)) |-> !nmi);

   assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[4:0] == 5'h1F);

   assert_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> (rdata == '1));
endmodule

bind nmi_ctl nmi_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
   .tmo_pulse(tmo_pulse), .motor_start(motor_start), .commit(commit),
   .en_irq(en.irq), .en_tmo(en.tmo), .tmo_q(tmo_q), .nmi(nmi), .rdata(rdata));

// File: tb/nmi_ctl_tb.sv
module nmi_ctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC = 2;

   logic clk = 0, rst_n = 0, wr_stb = 0, rd_stb = 0;
   logic [7:0] wdata = 0;
   logic fdc_irq = 0, tmo_pulse = 0, motor_start = 0, panel_btn = 0;
   logic nmi;
   logic [7:0] rdata;

   int n_chk = 0, n_fail = 0;
   logic m_en_irq = 0, m_en_tmo = 0, m_tmo = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nmi_ctl #(.DATA_W(8), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata),
      .fdc_irq(fdc_irq), .tmo_pulse(tmo_pulse), .motor_start(motor_start),
      .panel_btn(panel_btn), .nmi(nmi), .rdata(rdata));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status();
      return {~fdc_irq, ~m_tmo, ~panel_btn, 5'h1F};
   endfunction

   function automatic logic exp_nmi();
      return (m_en_irq & fdc_irq) | (m_en_tmo & m_tmo);
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Strobe high for `hold` cycles, then low; returns at the negedge after the load edge
   task automatic wr(input logic [7:0] d, input int hold);
      wr_stb = 1; wdata = d;
      cyc(hold);
      wr_stb = 0; wdata = ~d;
      cyc(1);
      m_en_irq = d[7]; m_en_tmo = d[6]; m_tmo = 0;
   endtask

   task automatic settle_check(input string tag);
      cyc(SYNC + 2);
      rd_stb = 1; #1;
      chk({tag, " R5/R6/R7 status"}, rdata, exp_status());
      chk({tag, " R3/R4 nmi"}, nmi, exp_nmi());
      rd_stb = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d2c));
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk("R1 nmi after reset", nmi, 0);
      rd_stb = 1; #1;
      chk("R1 status after reset", rdata, 8'hFF);
      rd_stb = 0; #1;
      chk("R7 idle bus", rdata, 8'hFF);

      // R2: strobe held high with request active and enable in data
      fdc_irq = 1;
      cyc(SYNC + 2);
      chk("R3 disabled request blocked", nmi, 0);
      wr_stb = 1; wdata = 8'h80;
      cyc(3);
      chk("R2 no load while strobe high", nmi, 0);
      wr_stb = 0; wdata = 8'h00;
      cyc(1);
      chk("R2 not yet visible on load edge", nmi, 0);
      cyc(1);
      chk("R2 loaded at falling strobe", nmi, 1);
      m_en_irq = 1;

      // R9 latency for the request
      fdc_irq = 0;
      cyc(SYNC + 2);
      chk("R9 nmi drops with request", nmi, 0);
      fdc_irq = 1;
      cyc(SYNC);
      chk("R9 nmi not early", nmi, 0);
      cyc(1);
      chk("R9 nmi at SYNC+1 edges", nmi, 1);

      // R10 low data bits ignored
      wr(8'h3F, 1);
      settle_check("R10 low bits 3F");
      wr(8'hBF, 2);
      settle_check("R10 low bits BF");
      fdc_irq = 0;

      // R4/R8/R9 timeout path
      wr(8'h40, 1);
      tmo_pulse = 1; cyc(1); tmo_pulse = 0;
      m_tmo = 1;
      rd_stb = 1; #1;
      chk("R8 flag set after pulse", rdata[6], 0);
      rd_stb = 0;
      chk("R9 tmo nmi not early", nmi, 0);
      cyc(1);
      chk("R9 tmo nmi at 2 edges", nmi, 1);
      cyc(5);
      chk("R8 flag sticky", nmi, 1);
      motor_start = 1; cyc(1); motor_start = 0;
      m_tmo = 0;
      settle_check("R8 restart clears");
      tmo_pulse = 1; cyc(1); tmo_pulse = 0;
      m_tmo = 1;
      settle_check("R8 set again");
      wr(8'h00, 1);
      settle_check("R8 write clears");
      tmo_pulse = 1; cyc(1); tmo_pulse = 0;
      m_tmo = 1;
      settle_check("R4 flag blocked when disabled");

      // R6 button
      panel_btn = 1;
      settle_check("R6 button pressed");
      panel_btn = 0;

      // Random phase
      for (int i = 0; i < 400; i++) begin
         int sel;
         sel = $urandom_range(0, 4);
         case (sel)
            0: wr(8'($urandom), $urandom_range(1, 3));
            1: fdc_irq = 1'($urandom);
            2: panel_btn = 1'($urandom);
            3: begin tmo_pulse = 1; cyc(1); tmo_pulse = 0; m_tmo = 1; end
            default: begin motor_start = 1; cyc(1); motor_start = 0; m_tmo = 0; end
         endcase
         settle_check("random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule